// File: doc/BRIEF.md
# Serial DDS Frequency Update Sequencer

This block sits on the host side of a serial direct digital synthesizer. It takes a 28-bit frequency tuning word and writes it to the synthesizer as a short burst of 16-bit serial words. Each word is framed by an active-low frame sync, shifted out MSB first on a data line, and clocked by a serial clock. The serial clock comes from the system clock through an integer divider.

A request arrives on a valid/ready handshake. It carries the tuning word and a mode bit. In full mode the block writes a control word, then the low 14 tuning bits, then the high 14 tuning bits. In fast mode it writes a control word and only the low 14 bits. The request is accepted only while ready is high. When the last frame sync has risen and the minimum idle gap has passed, a one-cycle done pulse marks the end of the update.

Top module: `dds_freq_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, dds_fsync_n and dds_sclk are 1, req_ready is 1 and done is 0.
- R2: In every frame, dds_fsync_n stays low for exactly 2*WORD_W*SCLK_HALF system clocks, and exactly WORD_W falling edges of dds_sclk occur inside it.
- R3: Bits go out MSB first. dds_sdata does not change while dds_sclk is low inside a frame, so the receiver can sample it on the falling edge.
- R4: A full update (req_full=1) sends exactly three words, in this order: CTRL_FULL (default 16'h2000), then {FREQ_SEL, req_tw[13:0]}, then {FREQ_SEL, req_tw[27:14]}. FREQ_SEL defaults to 2'b01 and sits in bits 15:14.
- R5: A fast update (req_full=0) sends exactly two words: CTRL_FAST (default 16'h0000), then {FREQ_SEL, req_tw[13:0]}. Tuning bits 27:14 have no effect in this mode.
- R6: Between two frames of the same update, dds_fsync_n stays high for at least 2*SCLK_HALF system clocks, which is one serial-clock period.
- R7: req_ready falls in the cycle after a request is accepted and stays low until done. A req_valid raised while req_ready is low neither changes the words being sent nor starts another update.
- R8: done is high for exactly one cycle. It rises exactly 2*SCLK_HALF system clocks after the last frame sync of the update rises.
- R9: Each level of dds_sclk inside a frame, including the high level before the first falling edge, lasts exactly SCLK_HALF system clocks.
- R10: Asserting rst_n in the middle of a word drives dds_fsync_n and dds_sclk high and req_ready high at once. The next request after reset completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_tw | input | TW_W (28) | Frequency tuning word |
| req_full | input | 1 | 1: full update (both halves); 0: fast update (low half only) |
| done | output | 1 | One-cycle pulse when the update has finished |
| dds_fsync_n | output | 1 | Active-low frame sync to the synthesizer |
| dds_sclk | output | 1 | Serial clock; idles high |
| dds_sdata | output | 1 | Serial data; changes on the rising edge of dds_sclk |

## Verification
Tuning words of all zeros and all ones expose a stuck data line or a missing bit. Alternating patterns and 0x1234567 expose a swapped half, a reversed bit order or a misplaced select prefix. Fast-mode words with non-zero high bits show whether a third word is sent or the wrong half goes out. The word 0x0003FFF, whose halves are all ones and all zeros, separates the low half from the high half at the 14-bit boundary. Directed cases raise req_valid while the block is busy, and assert reset in the middle of a word, to check that neither corrupts the next transfer.

// File: rtl/dds_load_pkg.sv
package dds_load_pkg;

  // Serial framing engine phases
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_GAP   = 2'd2
  } shift_st_e;

  // Word sequencing phases
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CTRL = 2'd1,
    SQ_LO   = 2'd2,
    SQ_HI   = 2'd3
  } seq_st_e;

endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF == 1) begin : g_pass
      assign tick = run;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
          cnt_d = '0;
        end else if (wrap) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = run && wrap;

      // R9
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

      // R9
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import dds_load_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              word_done,
  output logic              fsync_n,
  output logic              sclk,
  output logic              sdata
);

  localparam int unsigned BCW = $clog2(WORD_W + 1);
  localparam logic [BCW-1:0] BITS_ALL = BCW'(WORD_W);

  shift_st_e         st_q, st_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [BCW-1:0]    bits_q, bits_d;
  logic              sclk_q, sclk_d;
  logic              fsync_q, fsync_d;
  logic              gap_q, gap_d;

  always_comb begin
    st_d    = st_q;
    shreg_d = shreg_q;
    bits_d  = bits_q;
    sclk_d  = sclk_q;
    fsync_d = fsync_q;
    gap_d   = gap_q;
    unique case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_d    = SH_SHIFT;
          shreg_d = word;
          bits_d  = '0;
          fsync_d = 1'b0;
          sclk_d  = 1'b1;
        end
      end
      SH_SHIFT: begin
        if (tick) begin
          if (sclk_q) begin
            // falling edge: receiver samples the current MSB
            sclk_d = 1'b0;
            bits_d = bits_q + 1'b1;
          end else begin
            // rising edge: present next bit or close the frame
            sclk_d = 1'b1;
            if (bits_q == BITS_ALL) begin
              fsync_d = 1'b1;
              st_d    = SH_GAP;
              gap_d   = 1'b0;
            end else begin
              shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
            end
          end
        end
      end
      SH_GAP: begin
        if (tick) begin
          if (gap_q) begin
            st_d = SH_IDLE;
          end else begin
            gap_d = 1'b1;
          end
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      shreg_q <= '0;
      bits_q  <= '0;
      sclk_q  <= 1'b1;
      fsync_q <= 1'b1;
      gap_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      shreg_q <= shreg_d;
      bits_q  <= bits_d;
      sclk_q  <= sclk_d;
      fsync_q <= fsync_d;
      gap_q   <= gap_d;
    end
  end

  assign busy      = (st_q != SH_IDLE);
  assign word_done = (st_q == SH_GAP) && tick && gap_q;
  assign fsync_n   = fsync_q;
  assign sclk      = sclk_q;
  assign sdata     = shreg_q[WORD_W-1];

  // R3
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_q && !fsync_q) |=> (sclk_q || $stable(shreg_q[WORD_W-1])));

  // R2
  bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BITS_ALL);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_q) |-> (bits_q == BITS_ALL));

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == SH_IDLE));

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SH_IDLE) |-> (fsync_q && sclk_q));

endmodule

// File: rtl/update_sequencer.sv
module update_sequencer
  import dds_load_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned TW_W      = 28,
  parameter logic [WORD_W-1:0] CTRL_FULL = 16'h2000,
  parameter logic [WORD_W-1:0] CTRL_FAST = 16'h0000,
  parameter logic [SEL_W-1:0]  FREQ_SEL  = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TW_W-1:0]   req_tw,
  input  logic              req_full,
  output logic              req_ready,
  output logic              done,
  input  logic              word_done,
  output logic              start,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned HALF_W = WORD_W - SEL_W;

  seq_st_e         st_q, st_d;
  logic [TW_W-1:0] tw_q, tw_d;
  logic            full_q, full_d;
  logic            issued_q, issued_d;
  logic            done_q, done_d;

  assign req_ready = (st_q == SQ_IDLE);
  assign start     = (st_q != SQ_IDLE) && !issued_q;
  assign done      = done_q;

  always_comb begin
    unique case (st_q)
      SQ_CTRL: word = full_q ? CTRL_FULL : CTRL_FAST;
      SQ_LO:   word = {FREQ_SEL, tw_q[HALF_W-1:0]};
      SQ_HI:   word = {FREQ_SEL, tw_q[TW_W-1:HALF_W]};
      default: word = '0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    tw_d     = tw_q;
    full_d   = full_q;
    issued_d = issued_q;
    done_d   = 1'b0;
    if (start) begin
      issued_d = 1'b1;
    end
    unique case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          st_d     = SQ_CTRL;
          tw_d     = req_tw;
          full_d   = req_full;
          issued_d = 1'b0;
        end
      end
      SQ_CTRL: begin
        if (word_done) begin
          st_d     = SQ_LO;
          issued_d = 1'b0;
        end
      end
      SQ_LO: begin
        if (word_done) begin
          issued_d = 1'b0;
          if (full_q) begin
            st_d = SQ_HI;
          end else begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end
        end
      end
      SQ_HI: begin
        if (word_done) begin
          st_d     = SQ_IDLE;
          issued_d = 1'b0;
          done_d   = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      tw_q     <= '0;
      full_q   <= 1'b0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      tw_q     <= tw_d;
      full_q   <= full_d;
      issued_q <= issued_d;
      done_q   <= done_d;
    end
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  fast_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_HI) |-> full_q);

  // R7
  tw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(tw_q));

endmodule

// File: rtl/dds_freq_loader.sv
module dds_freq_loader #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned SCLK_HALF = 2,
  parameter logic [WORD_W-1:0] CTRL_FULL = 16'h2000,
  parameter logic [WORD_W-1:0] CTRL_FAST = 16'h0000,
  parameter logic [SEL_W-1:0]  FREQ_SEL  = 2'b01,
  localparam int unsigned TW_W = 2 * (WORD_W - SEL_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [TW_W-1:0] req_tw,
  input  logic            req_full,
  output logic            done,
  output logic            dds_fsync_n,
  output logic            dds_sclk,
  output logic            dds_sdata
);

  logic              tick;
  logic              sh_busy;
  logic              word_done;
  logic              start;
  logic [WORD_W-1:0] word;

  sclk_tick_gen #(
    .HALF (SCLK_HALF)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sh_busy),
    .tick  (tick)
  );

  update_sequencer #(
    .WORD_W    (WORD_W),
    .SEL_W     (SEL_W),
    .TW_W      (TW_W),
    .CTRL_FULL (CTRL_FULL),
    .CTRL_FAST (CTRL_FAST),
    .FREQ_SEL  (FREQ_SEL)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_tw    (req_tw),
    .req_full  (req_full),
    .req_ready (req_ready),
    .done      (done),
    .word_done (word_done),
    .start     (start),
    .word      (word)
  );

  frame_shifter #(
    .WORD_W (WORD_W)
  ) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (start),
    .word      (word),
    .busy      (sh_busy),
    .word_done (word_done),
    .fsync_n   (dds_fsync_n),
    .sclk      (dds_sclk),
    .sdata     (dds_sdata)
  );

  // R8
  done_fsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dds_fsync_n && req_ready));

endmodule

// File: tb/sim_dds_freq_loader.sv
module sim_dds_freq_loader;

  localparam int CLK_PERIOD = 10;
  localparam int H    = 2;
  localparam int TW_W = 28;
  localparam logic [15:0] C_FULL = 16'h2000;
  localparam logic [15:0] C_FAST = 16'h0000;
  localparam logic [1:0]  SEL    = 2'b01;
  localparam int NVEC = 6;
  // {full, tuning word}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 28'h0000000}, {1'b1, 28'hFFFFFFF}, {1'b1, 28'h5A5A5A5},
    {1'b0, 28'h1234567}, {1'b0, 28'hABCDEF0}, {1'b1, 28'h0003FFF}
  };

  logic clk, rst_n, req_valid, req_ready, req_full, done;
  logic dds_fsync_n, dds_sclk, dds_sdata;
  logic [TW_W-1:0] req_tw;

  int n_chk, n_bad, cyc;

  dds_freq_loader #(.SCLK_HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tw(req_tw), .req_full(req_full), .done(done),
    .dds_fsync_n(dds_fsync_n), .dds_sclk(dds_sclk), .dds_sdata(dds_sdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // line monitor, sampled away from the active edge
  logic [15:0] frames [8];
  int   nfr, cur_bits, low_len, gap_len, lvl_len, rise_age, done_age, done_w;
  int   hold_bad, half_bad, len_bad, bits_bad, gap_bad;
  logic [15:0] cur_word;
  logic p_fs, p_sck, p_sd;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      p_fs = 1'b1; p_sck = 1'b1; p_sd = 1'b0;
    end else begin
      rise_age = rise_age + 1;
      if (done) begin
        done_w = done_w + 1;
        if (done_w == 1) done_age = rise_age;
      end
      if (!dds_fsync_n && p_fs) begin
        if (nfr > 0 && gap_len < 2*H) gap_bad = gap_bad + 1;
        cur_bits = 0; cur_word = '0; low_len = 0; lvl_len = 0;
      end
      if (!dds_fsync_n) begin
        low_len = low_len + 1;
        if (dds_sclk != p_sck && !p_fs) begin
          if (lvl_len != H) half_bad = half_bad + 1;
          lvl_len = 1;
        end else begin
          lvl_len = lvl_len + 1;
        end
        if (p_sck && !dds_sclk) begin
          cur_word = {cur_word[14:0], dds_sdata};
          cur_bits = cur_bits + 1;
        end
        if (!dds_sclk && !p_sck && dds_sdata != p_sd) hold_bad = hold_bad + 1;
      end else begin
        gap_len = gap_len + 1;
      end
      if (dds_fsync_n && !p_fs) begin
        if (nfr < 8) frames[nfr] = cur_word;
        nfr = nfr + 1;
        if (low_len != 32*H) len_bad = len_bad + 1;
        if (cur_bits != 16) bits_bad = bits_bad + 1;
        gap_len = 1; rise_age = 0;
      end
      p_fs = dds_fsync_n; p_sck = dds_sclk; p_sd = dds_sdata;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [27:0] tw, input bit full, input int idx);
    if (idx == 0) return full ? C_FULL : C_FAST;
    if (idx == 1) return {SEL, tw[13:0]};
    return {SEL, tw[27:14]};
  endfunction

  task automatic clr_mon();
    nfr = 0; hold_bad = 0; half_bad = 0; len_bad = 0; bits_bad = 0; gap_bad = 0;
    done_age = -1; done_w = 0; gap_len = 0; rise_age = 0;
  endtask

  // send one request, optionally keep valid high while busy with other data
  task automatic run_req(input logic [27:0] tw, input bit full, input bit noisy, input string tag);
    int wait_c = 0;
    int busy_rdy = 0;
    int nexp = full ? 3 : 2;
    clr_mon();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_tw = tw; req_full = full;
    @(negedge clk);
    if (!noisy) req_valid = 1'b0;
    else begin req_tw = ~tw; req_full = ~full; end
    while (!done && wait_c < 2000) begin
      if (req_ready) busy_rdy++;
      @(negedge clk); wait_c++;
    end
    req_valid = 1'b0;
    repeat (4*H + 4) @(negedge clk);
    chk(nfr == nexp, {tag, " word count R4 R5"}, nfr, nexp);
    for (int i = 0; i < nexp && i < nfr; i++)
      chk(frames[i] == exp_word(tw, full, i), {tag, " word content R4 R5"}, frames[i], exp_word(tw, full, i));
    chk(hold_bad == 0 && bits_bad == 0, {tag, " R3 msb-first hold"}, hold_bad + bits_bad, 0);
    chk(len_bad == 0, {tag, " R2 frame length"}, len_bad, 0);
    chk(half_bad == 0, {tag, " R9 half period"}, half_bad, 0);
    chk(gap_bad == 0, {tag, " R6 inter-frame gap"}, gap_bad, 0);
    chk(done_age == 2*H && done_w == 1, {tag, " R8 done timing"}, done_age, 2*H);
    if (noisy) chk(busy_rdy == 0, {tag, " R7 ready low while busy"}, busy_rdy, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    req_valid = 1'b0; req_tw = '0; req_full = 1'b0;
    clr_mon();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(dds_fsync_n && dds_sclk && req_ready && !done, "R1 reset state",
        {dds_fsync_n, dds_sclk, req_ready, done}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dds_fsync_n && dds_sclk && req_ready && !done, "R1 after release",
        {dds_fsync_n, dds_sclk, req_ready, done}, 4'b1110);

    for (int v = 0; v < NVEC; v++)
      run_req(VEC[v][27:0], VEC[v][28], 1'b0, $sformatf("vec%0d", v));

    // R7: valid held high with other data while busy must be ignored
    run_req(28'h2468ACE, 1'b0, 1'b1, "busy-ignore");
    run_req(28'hC3C3C3C, 1'b1, 1'b1, "busy-ignore-full");

    // R10: reset in the middle of the second word
    @(negedge clk);
    req_valid = 1'b1; req_tw = 28'h7777777; req_full = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (34*H + 20) @(negedge clk);
    chk(!dds_fsync_n, "R10 mid-word precondition", dds_fsync_n, 0);
    rst_n = 1'b0;
    #1;
    chk(dds_fsync_n && dds_sclk && req_ready, "R10 reset mid-word",
        {dds_fsync_n, dds_sclk, req_ready}, 3'b111);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_req(28'h0F0F0F0, 1'b1, 1'b0, "after-abort R10");

    summary();
  end

endmodule